// File: doc/BRIEF.md
# Trimmable RTC Seconds Predivider

This block turns a slow real-time reference clock (nominally 32.768 kHz) into a one-second tick and a running count of seconds. A down-counting predivider is reloaded when it underflows. Most reloads use a fixed nominal constant. One reload in every window of seconds takes a software-written trim value instead. Raising or lowering that trim value by a few input cycles stretches or shortens one second per window, so a slow or fast crystal can be corrected on average.

Software writes the trim value through a single 32-bit register port and can read it back. A strobe preloads the seconds counter. The same strobe restarts the predivider and the trim window, so the count can be aligned to an external time base. An enable input freezes all counting while it is low.

Top module: `rtc_sec_predivider`

## Requirements
- R1: After reset the trim register reads back the nominal value (0x7FFF by default), the seconds count is zero and the tick output is low.
- R2: The low PRE_W bits of the trim register can be written and read back. Register bits from PRE_W up to 31 always read as zero, and writes to them are discarded.
- R3: Whenever the predivider reaches zero while counting, sec_tick is high for exactly one cycle, in the cycle after the zero count. The predivider then reloads. A second that was loaded with the nominal value N lasts N+1 input cycles.
- R4: One reload out of every 2^WIN_W takes the trim value T instead of N, namely the reload that closes the last second of the window. Any 2^WIN_W consecutive seconds therefore last 2^WIN_W*(N+1)+(T-N) input cycles in total.
- R5: Writing the trim register does not change the length of the second already in progress. The new value is first used at the next trim reload.
- R6: Each tick adds one to the seconds counter in the same cycle that sec_tick goes high. The counter wraps from all-ones to zero.
- R7: A sec_load pulse sets the seconds counter to sec_load_value, loads the nominal value into the predivider and restarts the window at its first second. This happens whatever the state of enable, and the first tick then follows N+1 cycles after the load.
- R8: While enable is low, the predivider, the window position and the seconds counter hold their values, and no tick is produced. A pause of P cycles lengthens the current second by P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (one cycle per RTC input period) |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Counting enable; low freezes all counters |
| trim_wr_en | input | 1 | Write strobe for the trim register |
| trim_wr_data | input | 32 | Write data; only the low PRE_W bits are kept |
| trim_rd_data | output | 32 | Trim register read-back, upper bits zero |
| sec_load | input | 1 | Preload strobe for the seconds counter; restarts predivider and window |
| sec_load_value | input | SEC_W | Value loaded into the seconds counter |
| sec_count | output | SEC_W | Free-running seconds count |
| sec_tick | output | 1 | One-cycle pulse at the end of each second |

## Verification
The bench builds the block with an 8-bit predivider, a nominal value of 0x1F (32 cycles per second) and a 3-bit window (8 seconds per window), which keeps the seconds counter at 32 bits. At these sizes a whole trim window takes a few hundred cycles. The bench can therefore time complete windows for trim values above, below and equal to nominal, including the extremes 0x00 and 0xFF, and it can also exercise the read-back masking of the upper register bits. Wrap of the 32-bit seconds counter is reached by preloading it near all-ones.

// File: rtl/rtcdiv_pkg.sv
// Package: rtcdiv_pkg
// Shared constants for the trimmable seconds predivider: the register bus
// width and the default sizes used when the top is elaborated stand-alone.
package rtcdiv_pkg;
    localparam int unsigned REG_W         = 32;
    localparam int unsigned DEF_PRE_W     = 16;
    localparam int unsigned DEF_WIN_W     = 6;
    localparam int unsigned DEF_SEC_W     = 32;
    localparam int unsigned DEF_NOMINAL   = 32'h0000_7FFF;
endpackage

// File: rtl/rtcdiv_trim_reg.sv
// Module: rtcdiv_trim_reg
// Holds the software trim value. Only the low PRE_W bits are stored. The
// read-back bus zero-extends them to the register width.
// Assumes PRE_W <= REG_W and that writes come from the same clock domain.
module rtcdiv_trim_reg
    import rtcdiv_pkg::*;
#(
    parameter int unsigned PRE_W   = DEF_PRE_W,
    parameter int unsigned NOMINAL = DEF_NOMINAL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [PRE_W-1:0] trim
);
    localparam logic [PRE_W-1:0] RESET_VAL = PRE_W'(NOMINAL);

    logic [PRE_W-1:0] trim_q;

    // Capture the low field of a register write; reset to the nominal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trim_q <= RESET_VAL;
        end else if (wr_en) begin
            trim_q <= wr_data[PRE_W-1:0];
        end
    end

    // Zero-extend the stored field onto the read bus.
    always_comb begin
        rd_data = '0;
        rd_data[PRE_W-1:0] = trim_q;
    end

    assign trim = trim_q;

    // R5: the trim value changes only through a write
    assert_trim_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(trim_q));

    // R2: a write lands exactly the low field
    assert_trim_captures_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> trim_q == $past(wr_data[PRE_W-1:0]));
endmodule

// File: rtl/rtcdiv_prediv_core.sv
// Module: rtcdiv_prediv_core
// Down-counting predivider with a window-position counter. An underflow
// while enabled reloads the counter with the nominal constant, or with the
// trim value when the window is on its last second, and produces a
// registered one-cycle tick. A load strobe restarts both counters.
// Assumes the trim input is stable apart from register writes.
module rtcdiv_prediv_core
    import rtcdiv_pkg::*;
#(
    parameter int unsigned PRE_W   = DEF_PRE_W,
    parameter int unsigned WIN_W   = DEF_WIN_W,
    parameter int unsigned NOMINAL = DEF_NOMINAL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [PRE_W-1:0] trim,
    output logic             wrap_evt,
    output logic             tick
);
    localparam logic [PRE_W-1:0] NOM_VAL  = PRE_W'(NOMINAL);
    localparam logic [WIN_W-1:0] WIN_LAST = '1;

    logic [PRE_W-1:0] cnt_q;
    logic [WIN_W-1:0] win_q;
    logic             tick_q;
    logic [PRE_W-1:0] reload_val;

    // Underflow happens on a zero count while counting and not restarting.
    assign wrap_evt   = enable && !restart && (cnt_q == '0);
    // The last second of the window is followed by a trim-length second.
    assign reload_val = (win_q == WIN_LAST) ? trim : NOM_VAL;

    // Count down, reload on underflow, restart on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= NOM_VAL;
            win_q <= '0;
        end else if (restart) begin
            cnt_q <= NOM_VAL;
            win_q <= '0;
        end else if (wrap_evt) begin
            cnt_q <= reload_val;
            win_q <= win_q + WIN_W'(1);
        end else if (enable) begin
            cnt_q <= cnt_q - PRE_W'(1);
        end
    end

    // Register the underflow into a one-cycle tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap_evt;
        end
    end

    assign tick = tick_q;

    // R3: an ordinary underflow reloads the nominal value
    assert_nominal_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !restart && cnt_q == '0 && win_q != WIN_LAST) |=> cnt_q == NOM_VAL);

    // R4: the underflow closing the window reloads the trim value
    assert_trim_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !restart && cnt_q == '0 && win_q == WIN_LAST) |=> cnt_q == $past(trim));

    // R7: a restart puts the predivider and window back to their start
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == NOM_VAL && win_q == '0));

    // R8: disabled counting freezes the predivider and window, no tick follows
    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !restart) |=> ($stable(cnt_q) && $stable(win_q) && !tick_q));

    // R3: a tick is only raised after an underflow cycle
    assert_tick_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_q) |-> $past(cnt_q) == '0);
endmodule

// File: rtl/rtcdiv_sec_counter.sv
// Module: rtcdiv_sec_counter
// Free-running seconds counter. It adds one on each predivider underflow
// and can be preloaded. The load has priority over counting.
// Assumes the increment strobe is never raised in a load cycle.
module rtcdiv_sec_counter
    import rtcdiv_pkg::*;
#(
    parameter int unsigned SEC_W = DEF_SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] load_value,
    input  logic             incr,
    output logic [SEC_W-1:0] count
);
    logic [SEC_W-1:0] sec_q;

    // Preload or advance the seconds count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
        end else if (load) begin
            sec_q <= load_value;
        end else if (incr) begin
            sec_q <= sec_q + SEC_W'(1);
        end
    end

    assign count = sec_q;

    // R6: each underflow adds exactly one, wrapping modulo 2^SEC_W
    assert_sec_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (incr && !load) |=> sec_q == $past(sec_q) + SEC_W'(1));

    // R7: a load takes the supplied value
    assert_sec_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sec_q == $past(load_value));

    // R8: without an underflow or a load the count holds
    assert_sec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!incr && !load) |=> $stable(sec_q));
endmodule

// File: rtl/rtc_sec_predivider.sv
// Module: rtc_sec_predivider
// Top of the trimmable seconds predivider. It ties the trim register, the
// predivider core and the seconds counter together.
// Assumes clk is the RTC reference clock and that all inputs are synchronous to it.
module rtc_sec_predivider
    import rtcdiv_pkg::*;
#(
    parameter int unsigned PRE_W   = DEF_PRE_W,
    parameter int unsigned WIN_W   = DEF_WIN_W,
    parameter int unsigned SEC_W   = DEF_SEC_W,
    parameter int unsigned NOMINAL = DEF_NOMINAL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trim_wr_en,
    input  logic [31:0]      trim_wr_data,
    output logic [31:0]      trim_rd_data,
    input  logic             sec_load,
    input  logic [SEC_W-1:0] sec_load_value,
    output logic [SEC_W-1:0] sec_count,
    output logic             sec_tick
);
    logic [PRE_W-1:0] trim_val;
    logic             wrap_evt;

    rtcdiv_trim_reg #(
        .PRE_W   (PRE_W),
        .NOMINAL (NOMINAL)
    ) u_trim (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (trim_wr_en),
        .wr_data (trim_wr_data),
        .rd_data (trim_rd_data),
        .trim    (trim_val)
    );

    rtcdiv_prediv_core #(
        .PRE_W   (PRE_W),
        .WIN_W   (WIN_W),
        .NOMINAL (NOMINAL)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .restart  (sec_load),
        .trim     (trim_val),
        .wrap_evt (wrap_evt),
        .tick     (sec_tick)
    );

    rtcdiv_sec_counter #(
        .SEC_W (SEC_W)
    ) u_secs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sec_load),
        .load_value (sec_load_value),
        .incr       (wrap_evt),
        .count      (sec_count)
    );

    // R2: the upper read-back bits never carry data
    assert_rd_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trim_wr_en |=> (trim_rd_data >> PRE_W) == 32'd0);

    // R6: a rising tick comes with a changed seconds count unless a load intervened
    assert_tick_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sec_tick) && !$past(sec_load)) |-> sec_count != $past(sec_count));
endmodule

// File: tb/tb_rtc_sec_predivider.sv
module tb_rtc_sec_predivider;
    localparam int unsigned PRE_W = 8;
    localparam int unsigned WIN_W = 3;
    localparam int unsigned SEC_W = 32;
    localparam int unsigned NOM   = 32'h1F;
    localparam int          SECS  = 1 << WIN_W;          // seconds per window
    localparam int          NOM_LEN = NOM + 1;           // cycles per nominal second

    // Vector table: trim value and expected length of 8 seconds that include one trim second
    localparam int NVEC = 5;
    localparam int VEC_TRIM [NVEC] = '{32'h1F, 32'h24, 32'h18, 32'h00, 32'hFF};
    localparam int VEC_EXP  [NVEC] = '{256, 261, 249, 225, 480};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             trim_wr_en = 1'b0;
    logic [31:0]      trim_wr_data = '0;
    logic [31:0]      trim_rd_data;
    logic             sec_load = 1'b0;
    logic [SEC_W-1:0] sec_load_value = '0;
    logic [SEC_W-1:0] sec_count;
    logic             sec_tick;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_sec_predivider #(
        .PRE_W(PRE_W), .WIN_W(WIN_W), .SEC_W(SEC_W), .NOMINAL(NOM)
    ) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .trim_wr_en(trim_wr_en), .trim_wr_data(trim_wr_data), .trim_rd_data(trim_rd_data),
        .sec_load(sec_load), .sec_load_value(sec_load_value),
        .sec_count(sec_count), .sec_tick(sec_tick)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_trim(input logic [31:0] v);
        @(negedge clk);
        trim_wr_data = v;
        trim_wr_en = 1'b1;
        @(negedge clk);
        trim_wr_en = 1'b0;
    endtask

    // Pulse sec_load; returns the cycle stamp seen just after the load edge
    task automatic do_load(input logic [SEC_W-1:0] v, output int stamp);
        @(negedge clk);
        sec_load_value = v;
        sec_load = 1'b1;
        @(negedge clk);
        sec_load = 1'b0;
        stamp = cyc;
    endtask

    // Waits for the next sampled tick and returns its cycle stamp
    task automatic wait_tick(output int stamp);
        int guard = 0;
        @(negedge clk);
        while (!sec_tick && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (!sec_tick) begin
            checks++;
            failures++;
            $display("FAIL watchdog: no tick actual=0 expected=1");
        end
        stamp = cyc;
    endtask

    initial begin
        #400000;
        checks++;
        failures++;
        $display("FAIL watchdog: run timed out actual=%0d expected<%0d", cyc, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int t0, t1, t2, tn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 trim reset", trim_rd_data, NOM);
        check("R1 seconds reset", sec_count, 0);
        check("R1 tick reset", sec_tick, 0);

        // R2: upper bits dropped, low field kept
        write_trim(32'hDEAD_BE5A);
        check("R2 readback masked", trim_rd_data, 32'h5A);

        enable = 1'b1;

        // R4: vector table, each with one trim second inside an 8-second span
        for (int i = 0; i < NVEC; i++) begin
            write_trim(VEC_TRIM[i]);
            do_load('0, t0);
            wait_tick(t1);
            for (int s = 0; s < SECS; s++) wait_tick(tn);
            check($sformatf("R4 window length vec%0d", i), tn - t1, VEC_EXP[i]);
            check($sformatf("R6 seconds after window vec%0d", i), sec_count, SECS + 1);
        end

        // R7: first tick follows a load by N+1 cycles; R3 tick is one cycle wide
        write_trim(NOM);
        do_load(32'h10, t0);
        wait_tick(t1);
        check("R7 first tick after load", t1 - t0, NOM_LEN);
        @(negedge clk);
        check("R3 tick one cycle", sec_tick, 0);

        // R5: a mid-window write does not touch the current second
        do_load('0, t0);
        wait_tick(t1);
        write_trim(32'h2F);
        wait_tick(t2);
        check("R5 current second unchanged", t2 - t1, NOM_LEN);
        for (int s = 0; s < SECS - 2; s++) wait_tick(t1);
        wait_tick(t2);
        check("R5 trim second uses new value", t2 - t1, 32'h2F + 1);
        wait_tick(t1);
        check("R3 nominal resumes after trim", t1 - t2, NOM_LEN);

        // R8: a 10-cycle pause stretches the second and freezes the count
        write_trim(NOM);
        do_load('0, t0);
        wait_tick(t1);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        tn = 0;
        repeat (10) begin
            @(negedge clk);
            if (sec_tick) tn++;
        end
        check("R8 no tick while disabled", tn, 0);
        check("R8 seconds held", sec_count, 1);
        enable = 1'b1;
        wait_tick(t2);
        check("R8 second stretched", t2 - t1, NOM_LEN + 10);

        // R6 and R7: preload near all-ones and watch the wrap
        do_load(32'hFFFF_FFFE, t0);
        check("R7 load value", sec_count, 32'hFFFF_FFFE);
        wait_tick(t1);
        check("R6 increment", sec_count, 32'hFFFF_FFFF);
        wait_tick(t1);
        check("R6 wrap to zero", sec_count, 0);

        // R7: load wins even with enable low
        enable = 1'b0;
        do_load(32'h55, t0);
        check("R7 load while disabled", sec_count, 32'h55);
        enable = 1'b1;
        wait_tick(t1);
        check("R7 restart after disabled load", t1 - t0, NOM_LEN);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule